// File: doc/BRIEF.md
# Graphics block-write masking datapath

This block is the write path of a 32-bit graphics frame memory. It takes one command per cycle from a valid/ready command stream. Three kinds of store are supported. A plain word write honours four per-byte mask lines. A write-per-bit store further limits the update to the bits set in a programmable bit-mask register. A block fill writes a stored colour word into any subset of eight adjacent columns with a single command.

The bit-mask and colour registers are loaded by a register-load command. One address bit picks which register takes the data word. All stores perform a read-merge-write against a small internal memory within the accepting cycle. A read command returns one word on a valid/ready response stream, so the stored contents can be observed through the block's normal interface.

Back-pressure rules: a command transfers on a rising edge where `cmd_valid` and `cmd_ready` are both high. A read response transfers on an edge where `rsp_valid` and `rsp_ready` are both high. While a response is waiting and `rsp_ready` is low, `cmd_ready` is low. During that time the response word stays unchanged. Once `cmd_valid` is raised, the command fields must be held until the transfer.

Top module: `gbw_write_path`

## Requirements
- R1: After reset, `rsp_valid` is 0, `cmd_ready` is 1, every memory word reads 0, the colour register is 0 and the bit-mask register is all ones.
- R2: A write command (`cmd_op`=1) replaces byte b of word `cmd_addr` with byte b of `cmd_data` only when `cmd_dqm[b]`=0. A byte whose `cmd_dqm` bit is 1 keeps its old value.
- R3: When `cmd_sf`=1 on a write or block fill, a bit is stored as (new & mask) | (old & ~mask). Here mask is the bit-mask register combined with the byte enables.
- R4: A block fill (`cmd_op`=2) targets the eight words whose address equals `cmd_addr` with its low 3 bits cleared. Word base+j is written only when `cmd_data[j]`=1. The low 3 address bits have no effect.
- R5: A block fill stores the colour register, not `cmd_data`.
- R6: During a block fill, a byte whose `cmd_dqm` bit is 1 keeps its old value in every column, regardless of the bit-mask register.
- R7: A register-load command (`cmd_op`=3) loads `cmd_data` into the bit-mask register when `cmd_addr[0]`=0, and into the colour register when `cmd_addr[0]`=1. It changes no memory word.
- R8: A read command (`cmd_op`=0) accepted at edge k raises `rsp_valid` after edge k, carrying the word stored before edge k. While `rsp_ready` is 0, `rsp_valid` and `rsp_data` hold and `cmd_ready` is 0.
- R9: A write command alters only the addressed word. No memory word changes in a cycle with no accepted store.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command present |
| cmd_ready | output | 1 | Command can be taken this cycle |
| cmd_op | input | 2 | 0 read, 1 write, 2 block fill, 3 register load |
| cmd_sf | input | 1 | Special function: apply the bit-mask register to the store |
| cmd_addr | input | AW (6) | Word address; bit 0 selects the register on a load |
| cmd_data | input | DW (32) | Write data, column enables [7:0] on a block fill, or register value |
| cmd_dqm | input | DW/8 (4) | Per-byte store inhibit, 1 = keep byte |
| rsp_valid | output | 1 | Read word present |
| rsp_ready | input | 1 | Consumer takes the read word |
| rsp_data | output | DW (32) | Read word |

## Verification
Every store takes effect on the edge that accepts it. A read accepted on the following edge therefore already returns the merged word, and its response is sampled on the falling edge after that acceptance. The bench drives each command on a falling edge and lowers `cmd_valid` just after the accepting rising edge. After every store, it reads back the whole eight-word group that the store could touch and compares each word against a model computed from the requirements. In the back-pressure test, `rsp_ready` is held low, and `cmd_ready` and `rsp_data` are sampled on several falling edges before release.

// File: rtl/gbw_pkg.sv
package gbw_pkg;
  typedef enum logic [1:0] {
    OP_READ  = 2'd0,
    OP_WRITE = 2'd1,
    OP_BLOCK = 2'd2,
    OP_LOAD  = 2'd3
  } gbw_op_e;
endpackage

// File: rtl/gbw_regs.sv
module gbw_regs #(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load_en,
  input  logic          sel_colour,
  input  logic [DW-1:0] din,
  output logic [DW-1:0] mask_q,
  output logic [DW-1:0] colour_q
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mask_q   <= '1;
      colour_q <= '0;
    end else if (load_en) begin
      if (sel_colour) colour_q <= din;
      else            mask_q   <= din;
    end
  end
endmodule

// File: rtl/gbw_merge.sv
module gbw_merge #(
  parameter int DW   = 32,
  parameter int COLS = 8,
  localparam int CB  = $clog2(COLS),
  localparam int NB  = DW / 8
) (
  input  logic                     op_wr,
  input  logic                     op_blk,
  input  logic                     sf,
  input  logic [CB-1:0]            col_sel,
  input  logic [DW-1:0]            data,
  input  logic [NB-1:0]            dqm,
  input  logic [DW-1:0]            mask,
  input  logic [DW-1:0]            colour,
  input  logic [COLS-1:0][DW-1:0]  old_words,
  output logic [COLS-1:0]          we,
  output logic [COLS-1:0][DW-1:0]  new_words
);
  logic [DW-1:0] byte_en;
  logic [DW-1:0] bit_en;
  logic [DW-1:0] src;

  for (genvar b = 0; b < NB; b++) begin : g_byte
    assign byte_en[b*8 +: 8] = {8{~dqm[b]}};
  end

  always_comb begin
    bit_en = sf ? (byte_en & mask) : byte_en;
    src    = op_blk ? colour : data;
  end

  for (genvar c = 0; c < COLS; c++) begin : g_col
    assign we[c]        = op_blk ? data[c] : (op_wr && (col_sel == CB'(c)));
    assign new_words[c] = (src & bit_en) | (old_words[c] & ~bit_en);
  end
endmodule

// File: rtl/gbw_mem.sv
module gbw_mem #(
  parameter int AW   = 6,
  parameter int DW   = 32,
  parameter int COLS = 8,
  localparam int CB    = $clog2(COLS),
  localparam int GW    = AW - CB,
  localparam int DEPTH = 1 << AW
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [GW-1:0]            grp,
  input  logic [COLS-1:0]          we,
  input  logic [COLS-1:0][DW-1:0]  new_words,
  output logic [COLS-1:0][DW-1:0]  old_words,
  input  logic                     rd_en,
  input  logic [AW-1:0]            rd_addr,
  output logic [DW-1:0]            rd_q
);
  logic [DW-1:0] store [DEPTH];

  always_comb begin
    for (int c = 0; c < COLS; c++) old_words[c] = store[{grp, CB'(c)}];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) store[i] <= '0;
      rd_q <= '0;
    end else begin
      for (int c = 0; c < COLS; c++) begin
        if (we[c]) store[{grp, CB'(c)}] <= new_words[c];
      end
      if (rd_en) rd_q <= store[rd_addr];
    end
  end
endmodule

// File: rtl/gbw_write_path.sv
module gbw_write_path #(
  parameter int AW   = 6,
  parameter int DW   = 32,
  parameter int COLS = 8,
  localparam int CB  = $clog2(COLS),
  localparam int NB  = DW / 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cmd_valid,
  output logic          cmd_ready,
  input  logic [1:0]    cmd_op,
  input  logic          cmd_sf,
  input  logic [AW-1:0] cmd_addr,
  input  logic [DW-1:0] cmd_data,
  input  logic [NB-1:0] cmd_dqm,
  output logic          rsp_valid,
  input  logic          rsp_ready,
  output logic [DW-1:0] rsp_data
);
  import gbw_pkg::*;

  logic                    accept;
  logic                    do_rd, do_wr, do_blk, do_ld;
  logic                    rsp_valid_q;
  logic [DW-1:0]           mask_q, colour_q;
  logic [COLS-1:0]         col_we;
  logic [COLS-1:0][DW-1:0] old_words, new_words;

  assign cmd_ready = !rsp_valid_q || rsp_ready;
  assign accept    = cmd_valid && cmd_ready;
  assign do_rd     = accept && (cmd_op == OP_READ);
  assign do_wr     = accept && (cmd_op == OP_WRITE);
  assign do_blk    = accept && (cmd_op == OP_BLOCK);
  assign do_ld     = accept && (cmd_op == OP_LOAD);

  always_ff @(posedge clk) begin
    if (!rst_n)         rsp_valid_q <= 1'b0;
    else if (do_rd)     rsp_valid_q <= 1'b1;
    else if (rsp_ready) rsp_valid_q <= 1'b0;
  end
  assign rsp_valid = rsp_valid_q;

  gbw_regs #(.DW(DW)) u_regs (
    .clk        (clk),
    .rst_n      (rst_n),
    .load_en    (do_ld),
    .sel_colour (cmd_addr[0]),
    .din        (cmd_data),
    .mask_q     (mask_q),
    .colour_q   (colour_q)
  );

  gbw_merge #(.DW(DW), .COLS(COLS)) u_merge (
    .op_wr     (do_wr),
    .op_blk    (do_blk),
    .sf        (cmd_sf),
    .col_sel   (cmd_addr[CB-1:0]),
    .data      (cmd_data),
    .dqm       (cmd_dqm),
    .mask      (mask_q),
    .colour    (colour_q),
    .old_words (old_words),
    .we        (col_we),
    .new_words (new_words)
  );

  gbw_mem #(.AW(AW), .DW(DW), .COLS(COLS)) u_mem (
    .clk       (clk),
    .rst_n     (rst_n),
    .grp       (cmd_addr[AW-1:CB]),
    .we        (col_we),
    .new_words (new_words),
    .old_words (old_words),
    .rd_en     (do_rd),
    .rd_addr   (cmd_addr),
    .rd_q      (rsp_data)
  );
endmodule

// File: rtl/gbw_write_path_chk.sv
module gbw_write_path_chk #(
  parameter int DW   = 32,
  parameter int COLS = 8
) (
  input logic            clk,
  input logic            rst_n,
  input logic            cmd_valid,
  input logic            cmd_ready,
  input logic [1:0]      cmd_op,
  input logic            rsp_valid,
  input logic            rsp_ready,
  input logic [DW-1:0]   rsp_data,
  input logic [COLS-1:0] col_we
);
  logic acc;
  assign acc = cmd_valid && cmd_ready;

  AST_READ_RESPONDS: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && cmd_op == 2'd0) |=> rsp_valid); // R8
  AST_RSP_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_data))); // R8
  AST_RSP_ORIGIN: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rsp_valid) |-> $past(acc && cmd_op == 2'd0)); // R8
  AST_LOAD_NO_STORE: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && cmd_op == 2'd3) |-> (col_we == '0)); // R7
  AST_WRITE_ONE_COL: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && cmd_op == 2'd1) |-> ($countones(col_we) == 1)); // R9
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !acc |-> (col_we == '0)); // R9
endmodule

bind gbw_write_path gbw_write_path_chk #(.DW(DW), .COLS(COLS)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cmd_valid (cmd_valid),
  .cmd_ready (cmd_ready),
  .cmd_op    (cmd_op),
  .rsp_valid (rsp_valid),
  .rsp_ready (rsp_ready),
  .rsp_data  (rsp_data),
  .col_we    (col_we)
);

// File: tb/gbw_write_path_tb.sv
module gbw_write_path_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_valid = 1'b0;
  logic        cmd_ready;
  logic [1:0]  cmd_op = 2'd0;
  logic        cmd_sf = 1'b0;
  logic [5:0]  cmd_addr = '0;
  logic [31:0] cmd_data = '0;
  logic [3:0]  cmd_dqm = '0;
  logic        rsp_valid;
  logic        rsp_ready = 1'b1;
  logic [31:0] rsp_data;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic [31:0] model [64];
  logic [31:0] mask_m;
  logic [31:0] colour_m;

  always #5 clk = ~clk;

  gbw_write_path u_dut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_op(cmd_op), .cmd_sf(cmd_sf), .cmd_addr(cmd_addr), .cmd_data(cmd_data),
    .cmd_dqm(cmd_dqm), .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
    .rsp_data(rsp_data)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] bits_on(input logic sf, input logic [3:0] dqm);
    logic [31:0] en;
    for (int b = 0; b < 4; b++) en[b*8 +: 8] = dqm[b] ? 8'h00 : 8'hFF;
    return sf ? (en & mask_m) : en;
  endfunction

  task automatic send(input logic [1:0] op, input logic sf, input logic [5:0] addr,
                      input logic [31:0] data, input logic [3:0] dqm);
    logic [31:0] en;
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = op; cmd_sf = sf;
    cmd_addr = addr; cmd_data = data; cmd_dqm = dqm;
    @(posedge clk);
    #1 cmd_valid = 1'b0;
    en = bits_on(sf, dqm);
    case (op)
      2'd1: model[addr] = (data & en) | (model[addr] & ~en);
      2'd2: for (int j = 0; j < 8; j++)
              if (data[j]) model[{addr[5:3], 3'(j)}] =
                (colour_m & en) | (model[{addr[5:3], 3'(j)}] & ~en);
      2'd3: if (addr[0]) colour_m = data; else mask_m = data;
      default: ;
    endcase
  endtask

  task automatic read_chk(input logic [5:0] addr, input string req);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = 2'd0; cmd_addr = addr;
    @(posedge clk);
    #1 cmd_valid = 1'b0;
    @(negedge clk);
    check(rsp_valid === 1'b1, {req, " rsp_valid"}, 32'(rsp_valid), 32'd1);
    check(rsp_data === model[addr], req, rsp_data, model[addr]);
  endtask

  task automatic group_chk(input logic [5:0] addr, input string req);
    for (int j = 0; j < 8; j++) read_chk({addr[5:3], 3'(j)}, req);
  endtask

  initial begin
    for (int i = 0; i < 64; i++) model[i] = '0;
    mask_m = '1; colour_m = '0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    check(rsp_valid === 1'b0, "R1 rsp_valid", 32'(rsp_valid), 32'd0);
    check(cmd_ready === 1'b1, "R1 cmd_ready", 32'(cmd_ready), 32'd1);
    group_chk(6'd40, "R1 memory clear");
    // R1: mask resets to all ones, so a write-per-bit store writes every bit
    send(2'd1, 1'b1, 6'd3, 32'hA5C3_5A3C, 4'h0);
    group_chk(6'd3, "R1 mask reset");
    // R1: colour resets to zero
    send(2'd1, 1'b0, 6'd50, 32'hFFFF_FFFF, 4'h0);
    send(2'd2, 1'b0, 6'd50, 32'h0000_0004, 4'h0);
    group_chk(6'd50, "R1 colour reset");

    // R2 / R9: plain writes, every byte-inhibit pattern
    for (int d = 0; d < 16; d++) begin
      logic [5:0] a;
      a = 6'((d * 3) % 64);
      send(2'd1, 1'b0, a, 32'h1F2E_3D4C * (d + 1) ^ 32'hFFFF_FFFF, 4'(d));
      group_chk(a, "R2 R9 plain write");
    end

    // R7: loads select by address bit 0 and leave memory untouched
    send(2'd3, 1'b0, 6'd8, 32'h0FF0_33CC, 4'hF);
    group_chk(6'd8, "R7 mask load no store");
    send(2'd3, 1'b1, 6'd9, 32'hC0DE_F00D, 4'h0);
    group_chk(6'd9, "R7 colour load no store");

    // R3: write-per-bit with every byte-inhibit pattern
    for (int d = 0; d < 16; d++) begin
      logic [5:0] a;
      a = 6'((d * 5 + 2) % 64);
      send(2'd1, 1'b1, a, ~(32'h0101_0101 * (d + 7)), 4'(d));
      group_chk(a, "R3 write-per-bit");
    end

    // R4 R5 R6: block fill over all 256 column-enable patterns
    for (int e = 0; e < 256; e++) begin
      logic [5:0] a;
      if (e % 16 == 0) begin
        send(2'd3, 1'b0, 6'd1, 32'h9E37_79B1 * (e + 1), 4'h0);
        send(2'd3, 1'b0, 6'd0, (e % 32 == 0) ? 32'hFFFF_FFFF : 32'hF00F_5AA5 ^ 32'(e), 4'h0);
      end
      a = 6'((e * 7 + 3) % 64);
      send(2'd2, 1'(e >> 1), a, {24'hABCDEF ^ 24'(e), 8'(e)},
           4'(e >> 4) ^ 4'(e));
      group_chk(a, "R4 R5 R6 block fill");
    end

    // R8: back-pressure holds the response and blocks commands
    send(2'd1, 1'b0, 6'd17, 32'h1234_5678, 4'h0);
    @(negedge clk);
    rsp_ready = 1'b0;
    cmd_valid = 1'b1; cmd_op = 2'd0; cmd_addr = 6'd17;
    @(posedge clk);
    #1 cmd_valid = 1'b0;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      check(rsp_valid === 1'b1, "R8 held valid", 32'(rsp_valid), 32'd1);
      check(rsp_data === 32'h1234_5678, "R8 held data", rsp_data, 32'h1234_5678);
      check(cmd_ready === 1'b0, "R8 cmd_ready low", 32'(cmd_ready), 32'd0);
    end
    rsp_ready = 1'b1;
    @(negedge clk);
    check(rsp_valid === 1'b0, "R8 released", 32'(rsp_valid), 32'd0);
    check(cmd_ready === 1'b1, "R8 ready again", 32'(cmd_ready), 32'd1);
    done = 1'b1;
  end

  initial begin
    int cyc;
    cyc = 0;
    while (!done && cyc < 150000) begin
      @(posedge clk);
      cyc++;
    end
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule